// File: doc/BRIEF.md
# Ternary Match Table with Sequential Address Report

This block is a small lookup table held in flip-flops. Each entry stores a value, a mask and a valid bit. A mask bit of 1 makes that bit position a don't-care, so one entry can stand for a whole family of binary words. The pattern `0000_01dd` is an example: value `0x04` with mask `0x03` covers every key from 4 to 7. Entries are loaded or overwritten at run time through a write port. A write takes one clock edge, sets the entry valid, and replaces its value and mask.

A search is started by raising `srch_req` with a key while `srch_rdy` is high. On the accepting edge the block compares the key against every entry in parallel and takes a private copy of the match vector. It then reports each matching address in binary, one per cycle, from lowest to highest, with a `hit_vld` strobe. A single-cycle `done` pulse follows the last address. The `found` flag tells whether the search had any match at all.

The controller has three states. `ST_IDLE` waits for a request, and an accepted request moves it to `ST_SCAN`. In `ST_SCAN` it pops the lowest pending match each cycle. It moves to `ST_DONE` when it pops the last pending match. It returns straight to `ST_IDLE` when nothing was pending. `ST_DONE` always moves to `ST_IDLE`.

Top module: `tcam_top`

## Requirements
- R1: A key matches an entry when every bit position whose mask bit is 0 holds the same value in key and entry. Positions whose mask bit is 1 match both 0 and 1.
- R2: After reset no entry is valid, and an invalid entry never matches. A write with `wr_en` high on a clock edge stores `wr_value` and `wr_mask` at `wr_addr` and makes that entry valid, replacing whatever the entry held before.
- R3: A search is accepted on a rising edge where `srch_req` and `srch_rdy` are both high. When at least one entry matches, the lowest matching address is on `hit_addr` with `hit_vld` high after the next rising edge, the second edge counting the accepting one.
- R4: Every matching address is reported exactly once, in ascending order, on consecutive cycles with `hit_vld` high. No address that does not match is ever reported.
- R5: `done` is high for exactly one cycle, in the cycle after the last reported address. When nothing matches, `done` is high in the cycle where the first address would otherwise have appeared, and `hit_vld` stays low.
- R6: `found` goes low when a search is accepted. It goes high with the first reported address and stays high through `done`. At `done` it is high exactly when the search had at least one match.
- R7: A write on the accepting edge, or on any edge while the search is in progress, does not change that search's results. The search sees the table as it stood before the accepting edge.
- R8: `srch_rdy` is low from the accepting edge until the cycle in which `done` is high, and is high again in that cycle. A request made while `srch_rdy` is low is ignored and starts no search.
- R9: After reset `srch_rdy` is high, and `hit_vld`, `done` and `found` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the entry table |
| wr_addr | input | AW | Entry index to write (AW = clog2(DEPTH)) |
| wr_value | input | WIDTH | Value to store |
| wr_mask | input | WIDTH | Don't-care mask to store, 1 = don't care |
| srch_req | input | 1 | Search request |
| srch_key | input | WIDTH | Key to look up |
| srch_rdy | output | 1 | High when a new search can be accepted |
| hit_vld | output | 1 | `hit_addr` carries a matching address |
| hit_addr | output | AW | Binary index of a matching entry |
| found | output | 1 | The current or last search had at least one match |
| done | output | 1 | One-cycle pulse ending a search |

## Verification
The bench keeps its own model of the table and derives the list of matching addresses from the mask rule for every search. It then checks the exact cycle of each strobe against that list.

Several corner cases are covered, each aimed at a specific fault:
- A search of an empty table with key zero catches a design that lets reset-cleared entries match.
- Keys at both edges of a don't-care range, and just outside it, catch a reversed mask polarity.
- A key that hits every entry catches a scanner that drops or repeats an address or reports them out of order.
- A zero-hit search catches a `done` pulse issued a cycle late or `found` left high from the previous search.
- A write issued on the accepting edge catches a design that compares against the updated table.
- A request raised while the block is busy catches a controller that starts a second, unwanted scan.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    // Scan controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } tcam_state_e;

endpackage

// File: rtl/tcam_store.sv
// Entry table: value, don't-care mask and valid bit per entry, in flip-flops.
module tcam_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [AW-1:0]                wr_addr,
    input  logic [WIDTH-1:0]             wr_value,
    input  logic [WIDTH-1:0]             wr_mask,
    output logic [DEPTH-1:0][WIDTH-1:0]  ent_val,
    output logic [DEPTH-1:0][WIDTH-1:0]  ent_msk,
    output logic [DEPTH-1:0]             ent_vld
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_addr == AW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_val[g] <= '0;
                ent_msk[g] <= '0;
                ent_vld[g] <= 1'b0;
            end else if (sel) begin
                ent_val[g] <= wr_value;
                ent_msk[g] <= wr_mask;
                ent_vld[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tcam_match.sv
// Parallel ternary comparison of one key against every entry.
module tcam_match #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]             key,
    input  logic [DEPTH-1:0][WIDTH-1:0]  ent_val,
    input  logic [DEPTH-1:0][WIDTH-1:0]  ent_msk,
    input  logic [DEPTH-1:0]             ent_vld,
    output logic [DEPTH-1:0]             hit_vec
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic [WIDTH-1:0] diff;
        assign diff       = (key ^ ent_val[g]) & ~ent_msk[g];
        assign hit_vec[g] = ent_vld[g] && (diff == '0);
    end

endmodule

// File: rtl/tcam_scan.sv
// Snapshots the match vector and reports the set bits lowest first.
module tcam_scan
    import tcam_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DEPTH-1:0]  hit_vec,
    output logic              rdy,
    output logic              hit_vld,
    output logic [AW-1:0]     hit_addr,
    output logic              found,
    output logic              done
);

    tcam_state_e      state, state_nx;
    logic [DEPTH-1:0] pend;
    logic [DEPTH-1:0] pend_clr;
    logic [AW-1:0]    low_idx;
    logic             any;

    // Lowest pending match and the vector without it
    always_comb begin
        low_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (pend[i]) low_idx = AW'(i);
        end
        pend_clr = pend & ~(DEPTH'(1) << low_idx);
        any      = |pend;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_SCAN;
            ST_SCAN: begin
                if (!any)                 state_nx = ST_IDLE;
                else if (pend_clr == '0)  state_nx = ST_DONE;
                else                      state_nx = ST_SCAN;
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Outputs and pending vector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend     <= '0;
            hit_vld  <= 1'b0;
            hit_addr <= '0;
            found    <= 1'b0;
            done     <= 1'b0;
        end else begin
            hit_vld <= 1'b0;
            done    <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        pend  <= hit_vec;
                        found <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (any) begin
                        hit_vld  <= 1'b1;
                        hit_addr <= low_idx;
                        pend     <= pend_clr;
                        found    <= 1'b1;
                    end else begin
                        done <= 1'b1;
                    end
                end
                ST_DONE: done <= 1'b1;
                default: ;
            endcase
        end
    end

    assign rdy = (state == ST_IDLE);

endmodule

// File: rtl/tcam_top.sv
// Ternary match table with run-time writes and sequential encoded report.
module tcam_top #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WIDTH-1:0]  wr_value,
    input  logic [WIDTH-1:0]  wr_mask,
    input  logic              srch_req,
    input  logic [WIDTH-1:0]  srch_key,
    output logic              srch_rdy,
    output logic              hit_vld,
    output logic [AW-1:0]     hit_addr,
    output logic              found,
    output logic              done
);

    logic [DEPTH-1:0][WIDTH-1:0] ent_val;
    logic [DEPTH-1:0][WIDTH-1:0] ent_msk;
    logic [DEPTH-1:0]            ent_vld;
    logic [DEPTH-1:0]            hit_vec;

    tcam_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_value (wr_value),
        .wr_mask  (wr_mask),
        .ent_val  (ent_val),
        .ent_msk  (ent_msk),
        .ent_vld  (ent_vld)
    );

    tcam_match #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_match (
        .key      (srch_key),
        .ent_val  (ent_val),
        .ent_msk  (ent_msk),
        .ent_vld  (ent_vld),
        .hit_vec  (hit_vec)
    );

    tcam_scan #(.DEPTH(DEPTH)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (srch_req),
        .hit_vec  (hit_vec),
        .rdy      (srch_rdy),
        .hit_vld  (hit_vld),
        .hit_addr (hit_addr),
        .found    (found),
        .done     (done)
    );

endmodule

// File: rtl/tcam_chk.sv
// Protocol checker bound to the top module.
module tcam_chk #(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          srch_req,
    input logic          srch_rdy,
    input logic          hit_vld,
    input logic [AW-1:0] hit_addr,
    input logic          found,
    input logic          done
);

    // R4
    ascending_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vld && $past(hit_vld)) |-> (hit_addr > $past(hit_addr)));

    // R4
    addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vld |-> (int'(hit_addr) < DEPTH));

    // R5
    done_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_vld && done));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    found_with_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vld |-> found);

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_req && srch_rdy) |=> !srch_rdy);

    // R8
    ready_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> srch_rdy);

    // R8
    busy_while_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vld |-> !srch_rdy);

endmodule

bind tcam_top tcam_chk #(.DEPTH(DEPTH)) u_tcam_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .srch_req (srch_req),
    .srch_rdy (srch_rdy),
    .hit_vld  (hit_vld),
    .hit_addr (hit_addr),
    .found    (found),
    .done     (done)
);

// File: tb/test_tcam_top.sv
module test_tcam_top;

    localparam int DEPTH = 8;
    localparam int WIDTH = 8;
    localparam int AW    = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [WIDTH-1:0] wr_value = '0;
    logic [WIDTH-1:0] wr_mask = '0;
    logic             srch_req = 1'b0;
    logic [WIDTH-1:0] srch_key = '0;
    logic             srch_rdy, hit_vld, found, done;
    logic [AW-1:0]    hit_addr;

    int total = 0;
    int bad   = 0;

    // Bench model of the table
    logic [WIDTH-1:0] m_val [DEPTH];
    logic [WIDTH-1:0] m_msk [DEPTH];
    logic             m_vld [DEPTH];

    always #2 clk = ~clk;

    tcam_top #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_tcam_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_value(wr_value), .wr_mask(wr_mask), .srch_req(srch_req),
        .srch_key(srch_key), .srch_rdy(srch_rdy), .hit_vld(hit_vld),
        .hit_addr(hit_addr), .found(found), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_entry(input int a, input logic [WIDTH-1:0] v, input logic [WIDTH-1:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_value = v; wr_mask = m;
        @(negedge clk);
        wr_en = 1'b0;
        m_val[a] = v; m_msk[a] = m; m_vld[a] = 1'b1;
    endtask

    // Runs one search and checks every strobe against the bench model.
    // with_wr: write an entry on the accepting edge (R7).
    // poke: raise srch_req again while busy (R8).
    task automatic run_search(input logic [WIDTH-1:0] key, input bit with_wr,
                              input int wa, input logic [WIDTH-1:0] wv,
                              input logic [WIDTH-1:0] wm, input bit poke);
        int exp_list[$];
        int k;
        int n;
        int got;
        bit fin;
        for (int i = 0; i < DEPTH; i++) begin
            if (m_vld[i] && (((key ^ m_val[i]) & ~m_msk[i]) == '0)) exp_list.push_back(i);
        end
        k = exp_list.size();
        @(negedge clk);
        check(srch_rdy == 1'b1, "R8 ready before search", int'(srch_rdy), 1);
        srch_req = 1'b1; srch_key = key;
        if (with_wr) begin
            wr_en = 1'b1; wr_addr = AW'(wa); wr_value = wv; wr_mask = wm;
        end
        @(negedge clk);
        srch_req = 1'b0; wr_en = 1'b0;
        if (with_wr) begin
            m_val[wa] = wv; m_msk[wa] = wm; m_vld[wa] = 1'b1;
        end
        check(srch_rdy == 1'b0, "R8 busy after accept", int'(srch_rdy), 0);
        n = 0; got = 0; fin = 1'b0;
        while (!fin && n < 4 * DEPTH) begin
            if (poke && n == 1) begin
                srch_req = 1'b1; srch_key = '1;
            end
            @(negedge clk);
            srch_req = 1'b0;
            n++;
            if (hit_vld) begin
                if (got < k) check(int'(hit_addr) == exp_list[got], "R4 address order",
                                   int'(hit_addr), exp_list[got]);
                else check(1'b0, "R4 extra address", int'(hit_addr), -1);
                check(n == got + 1, "R3/R4 hit cycle", n, got + 1);
                got++;
            end
            if (done) begin
                fin = 1'b1;
                check(n == k + 1, "R5 done cycle", n, k + 1);
                check(found == (k > 0), "R6 found at done", int'(found), int'(k > 0));
                check(srch_rdy == 1'b1, "R8 ready at done", int'(srch_rdy), 1);
            end
        end
        check(fin, "R5 done seen", int'(fin), 1);
        check(got == k, "R4 hit count", got, k);
    endtask

    task automatic t_reset;
        check(srch_rdy == 1'b1, "R9 rdy", int'(srch_rdy), 1);
        check(hit_vld == 1'b0, "R9 hit_vld", int'(hit_vld), 0);
        check(done == 1'b0, "R9 done", int'(done), 0);
        check(found == 1'b0, "R9 found", int'(found), 0);
        // R2: cleared entries hold zero but must not match key zero
        run_search(8'h00, 1'b0, 0, 0, 0, 1'b0);
    endtask

    task automatic t_ternary;
        // R1: value 0x04 mask 0x03 covers keys 4..7
        write_entry(2, 8'h04, 8'h03);
        run_search(8'h04, 1'b0, 0, 0, 0, 1'b0);
        run_search(8'h07, 1'b0, 0, 0, 0, 1'b0);
        run_search(8'h08, 1'b0, 0, 0, 0, 1'b0);
        run_search(8'h03, 1'b0, 0, 0, 0, 1'b0);
        check(found == 1'b0, "R6 found low on miss", int'(found), 0);
    endtask

    task automatic t_multi;
        // R4: several overlapping entries
        write_entry(6, 8'h00, 8'h0F);
        write_entry(1, 8'h05, 8'h00);
        write_entry(4, 8'hF5, 8'h00);
        run_search(8'h05, 1'b0, 0, 0, 0, 1'b0);
        run_search(8'h0C, 1'b0, 0, 0, 0, 1'b0);
    endtask

    task automatic t_all;
        // R4: every entry matches
        for (int i = 0; i < DEPTH; i++) write_entry(i, 8'h00, 8'hFF);
        run_search(8'hA5, 1'b0, 0, 0, 0, 1'b0);
    endtask

    task automatic t_overwrite;
        // R2: overwrite changes the result
        write_entry(3, 8'h77, 8'h00);
        run_search(8'h12, 1'b0, 0, 0, 0, 1'b0);
        run_search(8'h77, 1'b0, 0, 0, 0, 1'b0);
    endtask

    task automatic t_same_cycle;
        logic [WIDTH-1:0] sv_v;
        logic [WIDTH-1:0] sv_m;
        for (int i = 0; i < DEPTH; i++) write_entry(i, 8'h10 + 8'(i), 8'h00);
        // R7: expected list uses the table before the write
        run_search(8'h99, 1'b1, 5, 8'h99, 8'h00, 1'b0);
        run_search(8'h99, 1'b0, 0, 0, 0, 1'b0);
        // R7: write removing a match on the accepting edge leaves it reported
        sv_v = m_val[2]; sv_m = m_msk[2];
        run_search(8'h12, 1'b1, 2, 8'h55, 8'h00, 1'b0);
        check(sv_v == 8'h12 && sv_m == 8'h00, "R7 prior entry", int'(sv_v), 8'h12);
    endtask

    task automatic t_busy;
        for (int i = 0; i < DEPTH; i++) write_entry(i, 8'(i), 8'h01);
        // R8: request during scan is ignored
        run_search(8'h02, 1'b0, 0, 0, 0, 1'b1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!hit_vld && !done, "R8 no extra search", int'(hit_vld || done), 0);
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_val[i] = '0; m_msk[i] = '0; m_vld[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ternary();
        t_multi();
        t_all();
        t_overwrite();
        t_same_cycle();
        t_busy();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule